// File: doc/BRIEF.md
# Serially Loaded Masked Trigger Comparator

This block produces the trigger for a logic-analyzer front end. On every sample clock it compares the captured sample word with a stored reference word. Each bit can be excluded from that comparison by its own don't-care flag. A small group of bus-control qualifier inputs, such as select, read, write or interrupt strobes, must also be satisfied. When the word and the qualifiers agree while the block is armed, a registered trigger pulse one sample clock long is produced. The block then disarms itself.

All settings arrive over a two-wire serial link: a serial clock and a serial data line. The settings are the reference word, the don't-care flags, and an enable and an expected level for each qualifier. Both serial lines are oversampled in the sample clock domain. A separate load strobe copies a complete frame into the working registers in one cycle. A frame that is short of bits is discarded at the strobe, so the comparison never sees a half-written setting.

Top module: `serial_trigger_cmp`

## Requirements
- R1: After reset the trigger output is low and the block is disarmed. The working settings are a reference word of zero, all don't-care flags set, and all qualifiers disabled, so the first armed sample of any value fires.
- R2: On each rising edge of the serial clock, one bit of serial data enters the frame, most significant bit first. A frame has FL = 2*W + 2*Q bits sent in this order: the W reference bits, the W don't-care bits, the Q qualifier enable bits, then the Q expected-level bits. Within each field the highest-numbered bit is sent first.
- R3: A rising edge of the load strobe copies the frame into the working settings only if at least FL bits arrived since the previous strobe. Otherwise the working settings are left unchanged. In both cases the bit count starts again from zero.
- R4: If more than FL bits arrive before the strobe, the last FL bits received form the frame.
- R5: A sample bit whose don't-care flag is 1 never blocks a match. A bit whose flag is 0 must equal the reference bit.
- R6: A qualifier whose enable bit is 1 must equal its expected-level bit. A qualifier whose enable bit is 0 is ignored.
- R7: If the sample and the qualifiers match in a clock cycle while the block is armed, the trigger is high for exactly the next cycle.
- R8: Firing disarms the block. The block stays disarmed, with the trigger low, until the next rising edge of the arm input. Holding arm high does not re-arm the block, and an arm edge in the same cycle as a firing is dropped.
- R9: A rising edge of arm takes effect from the following cycle, so a matching sample in the cycle of the arm edge does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial configuration clock, oversampled |
| ser_dat | input | 1 | Serial configuration data |
| ser_load | input | 1 | Load strobe; a rising edge commits the frame |
| sample | input | W | Captured sample word |
| qual | input | Q | Bus-control qualifier inputs |
| arm | input | 1 | A rising edge arms the trigger |
| trig | output | 1 | Registered one-cycle trigger pulse |

## Verification
The hardest case to reach from the ports is a match that coincides with the arm edge, or that follows a firing while arm is still held high. Random data almost never matches a 24-bit word, so these cases do not arise by chance. The stimulus therefore builds matching samples from the current settings and fills only the don't-care bits and the disabled qualifiers at random. It also raises arm often and at random, so that arm edges land on matching cycles. The bench also sends short frames and overlong frames before a strobe, to show that the comparison keeps the old settings or takes only the last FL bits.

// File: rtl/trig_cmp_pkg.sv
package trig_cmp_pkg;
  localparam int MAXW = 32;
  localparam int MAXQ = 8;

  // A bit passes when its don't-care flag is set or it equals the reference bit.
  function automatic logic word_hit(input logic [MAXW-1:0] ref_w,
                                    input logic [MAXW-1:0] dc_w,
                                    input logic [MAXW-1:0] smp_w);
    return &(~(ref_w ^ smp_w) | dc_w);
  endfunction

  // A qualifier passes when it is disabled or sits at its expected level.
  function automatic logic qual_hit(input logic [MAXQ-1:0] en_q,
                                    input logic [MAXQ-1:0] lvl_q,
                                    input logic [MAXQ-1:0] in_q);
    return &(~en_q | ~(lvl_q ^ in_q));
  endfunction
endpackage

// File: rtl/ser_frontend.sv
module ser_frontend #(
  parameter int FL   = 56,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_load,
  output logic [FL-1:0] frame,
  output logic          frame_full,
  output logic          ser_rise,
  output logic          ser_bit,
  output logic          load_rise
);
  localparam int CW = $clog2(FL + 1);

  logic [SYNC:0]   ck_s;
  logic [SYNC:0]   ld_s;
  logic [SYNC-1:0] dt_s;
  logic [CW-1:0]   bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      ld_s <= '0;
      dt_s <= '0;
    end else begin
      ck_s <= {ck_s[SYNC-1:0], ser_clk};
      ld_s <= {ld_s[SYNC-1:0], ser_load};
      dt_s <= {dt_s[SYNC-2:0], ser_dat};
    end
  end

  assign ser_rise  = ck_s[SYNC-1] & ~ck_s[SYNC];
  assign load_rise = ld_s[SYNC-1] & ~ld_s[SYNC];
  assign ser_bit   = dt_s[SYNC-1];
  assign frame_full = (bit_cnt == CW'(FL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else begin
      if (ser_rise)
        frame <= {frame[FL-2:0], ser_bit};
      if (load_rise)
        bit_cnt <= '0;
      else if (ser_rise && !frame_full)
        bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int W = 24,
  parameter int Q = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [2*W+2*Q-1:0]   frame,
  output logic [W-1:0]         ref_w,
  output logic [W-1:0]         dc_w,
  output logic [Q-1:0]         qen,
  output logic [Q-1:0]         qlvl
);
  localparam int FL = 2*W + 2*Q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_w <= '0;
      dc_w  <= '1;
      qen   <= '0;
      qlvl  <= '0;
    end else if (commit) begin
      ref_w <= frame[FL-1 -: W];
      dc_w  <= frame[FL-1-W -: W];
      qen   <= frame[2*Q-1 -: Q];
      qlvl  <= frame[Q-1:0];
    end
  end
endmodule

// File: rtl/trig_core.sv
module trig_core
  import trig_cmp_pkg::*;
#(
  parameter int W = 24,
  parameter int Q = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ref_w,
  input  logic [W-1:0] dc_w,
  input  logic [Q-1:0] qen,
  input  logic [Q-1:0] qlvl,
  input  logic [W-1:0] sample,
  input  logic [Q-1:0] qual,
  input  logic         arm,
  output logic         trig,
  output logic         armed,
  output logic         match,
  output logic         arm_rise,
  output logic         hit
);
  logic arm_d;

  assign match = word_hit(MAXW'(ref_w), MAXW'(dc_w), MAXW'(sample))
               & qual_hit(MAXQ'(qen), MAXQ'(qlvl), MAXQ'(qual));
  assign arm_rise = arm & ~arm_d;
  assign hit      = armed & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_d <= 1'b0;
      armed <= 1'b0;
      trig  <= 1'b0;
    end else begin
      arm_d <= arm;
      trig  <= hit;
      if (hit)
        armed <= 1'b0;
      else if (arm_rise)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_trigger_cmp.sv
module serial_trigger_cmp #(
  parameter int W    = 24,
  parameter int Q    = 4,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_dat,
  input  logic         ser_load,
  input  logic [W-1:0] sample,
  input  logic [Q-1:0] qual,
  input  logic         arm,
  output logic         trig
);
  localparam int FL = 2*W + 2*Q;

  logic [FL-1:0] frame;
  logic          frame_full, ser_rise, ser_bit, load_rise, commit;
  logic [W-1:0]  ref_w, dc_w;
  logic [Q-1:0]  qen, qlvl;
  logic          armed, match, arm_rise, hit;

  assign commit = load_rise & frame_full;

  ser_frontend #(.FL(FL), .SYNC(SYNC)) fe_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .frame(frame), .frame_full(frame_full),
    .ser_rise(ser_rise), .ser_bit(ser_bit), .load_rise(load_rise)
  );

  cfg_bank #(.W(W), .Q(Q)) cfg_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .frame(frame),
    .ref_w(ref_w), .dc_w(dc_w), .qen(qen), .qlvl(qlvl)
  );

  trig_core #(.W(W), .Q(Q)) core_i (
    .clk(clk), .rst_n(rst_n), .ref_w(ref_w), .dc_w(dc_w), .qen(qen),
    .qlvl(qlvl), .sample(sample), .qual(qual), .arm(arm), .trig(trig),
    .armed(armed), .match(match), .arm_rise(arm_rise), .hit(hit)
  );
endmodule

// File: rtl/serial_trigger_cmp_chk.sv
module serial_trigger_cmp_chk #(
  parameter int W  = 24,
  parameter int Q  = 4,
  parameter int FL = 2*W + 2*Q
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              armed,
  input logic              match,
  input logic              arm_rise,
  input logic              ser_rise,
  input logic              ser_bit,
  input logic              load_rise,
  input logic              frame_full,
  input logic [FL-1:0]     frame,
  input logic [2*W+2*Q-1:0] cfg_now
);
  // R7: the pulse lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R7: a pulse is caused by an armed match one cycle before
  a_r7_armed_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed && match));

  // R8: firing leaves the block disarmed
  a_r8_disarm_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !armed);

  // R9: arming only follows an arm edge
  a_r9_arm_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(arm_rise));

  // R3: a short frame leaves the working settings untouched
  a_r3_short_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && !frame_full) |=> $stable(cfg_now));

  // R2: each serial edge shifts the sampled bit into the low end
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rise |=> (frame[0] == $past(ser_bit)));
endmodule

bind serial_trigger_cmp serial_trigger_cmp_chk #(.W(W), .Q(Q)) chk_i (
  .clk(clk), .rst_n(rst_n), .trig(trig), .armed(armed), .match(match),
  .arm_rise(arm_rise), .ser_rise(ser_rise), .ser_bit(ser_bit),
  .load_rise(load_rise), .frame_full(frame_full), .frame(frame),
  .cfg_now({ref_w, dc_w, qen, qlvl})
);

// File: tb/serial_trigger_cmp_tb_top.sv
module serial_trigger_cmp_tb_top;
  localparam int W  = 24;
  localparam int Q  = 4;
  localparam int FL = 2*W + 2*Q;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
  logic [W-1:0] sample = '0;
  logic [Q-1:0] qual = '0;
  logic arm = 1'b0;
  logic trig;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // model state
  logic [W-1:0] m_ref = '0;
  logic [W-1:0] m_dc = '1;
  logic [Q-1:0] m_en = '0;
  logic [Q-1:0] m_lvl = '0;
  logic m_armed = 1'b0;
  logic m_arm_prev = 1'b0;

  always #5 clk = ~clk;

  serial_trigger_cmp #(.W(W), .Q(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .sample(sample), .qual(qual), .arm(arm), .trig(trig)
  );

  function automatic logic exp_match(input logic [W-1:0] s, input logic [Q-1:0] q);
    logic ok = 1'b1;
    for (int i = 0; i < W; i++)
      if (!m_dc[i] && (s[i] != m_ref[i])) ok = 1'b0;
    for (int j = 0; j < Q; j++)
      if (m_en[j] && (q[j] != m_lvl[j])) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: trig actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One sample cycle; entered and left at a falling edge.
  task automatic step(input string tag, input logic [W-1:0] s,
                      input logic [Q-1:0] q, input logic a);
    logic h;
    sample = s; qual = q; arm = a;
    @(posedge clk);
    h = m_armed & exp_match(s, q);
    if (h) m_armed = 1'b0;
    else if (a && !m_arm_prev) m_armed = 1'b1;
    m_arm_prev = a;
    @(negedge clk);
    check(tag, trig, h);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    ser_load = 1'b1;
    repeat (4) @(negedge clk);
    ser_load = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // Leaves the block disarmed whatever happened while unchecked.
  task automatic drain();
    arm = 1'b0;
    sample = m_ref; qual = m_lvl;
    repeat (3) @(negedge clk);
    m_armed = 1'b0; m_arm_prev = 1'b0;
  endtask

  task automatic load_cfg(input logic [W-1:0] r, input logic [W-1:0] d,
                          input logic [Q-1:0] e, input logic [Q-1:0] l,
                          input int extra, input int drop);
    logic [FL-1:0] f;
    f = {r, d, e, l};
    arm = 1'b0;
    for (int k = 0; k < extra; k++) send_bit(1'($urandom));
    for (int k = FL-1; k >= drop; k--) send_bit(f[k]);
    strobe();
    if (drop == 0) begin
      m_ref = r; m_dc = d; m_en = e; m_lvl = l;
    end
    drain();
  endtask

  task automatic rand_vectors(input string tag, input int n);
    logic [W-1:0] s;
    logic [Q-1:0] q;
    for (int k = 0; k < n; k++) begin
      if ($urandom % 3 != 0) begin
        s = (m_ref & ~m_dc) | (W'($urandom) & m_dc);
        q = (m_lvl & m_en) | (Q'($urandom) & ~m_en);
        if ($urandom % 5 == 0) s[$urandom % W] ^= 1'b1;
        if ($urandom % 5 == 0) q[$urandom % Q] ^= 1'b1;
      end else begin
        s = W'($urandom); q = Q'($urandom);
      end
      step(tag, s, q, ($urandom % 4 == 0));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset low", trig, 1'b0);
    // R1: default settings match anything once armed
    step("R1 idle", 24'h5A5A5A, 4'hF, 1'b0);
    step("R9 arm edge", 24'h123456, 4'h3, 1'b1);
    step("R1 default fires", 24'hABCDEF, 4'h9, 1'b1);
    step("R8 held arm", 24'h000001, 4'h0, 1'b1);
    step("R8 held arm", 24'h000002, 4'h0, 1'b1);
    step("R8 release", 24'h000003, 4'h0, 1'b0);

    // R5 R6: exact word, two qualifiers enabled
    load_cfg(24'hC3_5A_0F, 24'h000000, 4'b0101, 4'b0100, 0, 0);
    step("R9 arm", 24'hC35A0F, 4'b0100, 1'b1);
    step("R5 one bit off", 24'hC35A0E, 4'b0100, 1'b0);
    step("R6 qual off", 24'hC35A0F, 4'b0101, 1'b0);
    step("R6 disabled qual", 24'hC35A0F, 4'b1110, 1'b0);
    step("R7 after fire", 24'hC35A0F, 4'b0100, 1'b0);
    step("R8 rearm", 24'hC35A0F, 4'b0100, 1'b1);
    step("R8 rearmed fires", 24'hC35A0F, 4'b0100, 1'b0);

    // R3: short frame must be ignored
    load_cfg(24'h111111, 24'h000000, 4'hF, 4'hF, 0, 3);
    step("R3 arm", 24'h000000, 4'h0, 1'b1);
    step("R3 old cfg kept", 24'hC35A0F, 4'b0100, 1'b0);

    // R4: leading surplus bits dropped
    load_cfg(24'hF0F0F0, 24'h00FF00, 4'b1000, 4'b1000, 7, 0);
    rand_vectors("R4 overlong frame", 60);

    for (int c = 0; c < 25; c++) begin
      load_cfg(W'($urandom), W'($urandom) & W'($urandom), Q'($urandom), Q'($urandom), 0, 0);
      rand_vectors("R7 random", 80);
    end
    load_cfg(24'h0F0F0F, 24'hFFFFFF, 4'h0, 4'h0, 0, 0);
    rand_vectors("R5 all dont-care", 40);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule